// File: doc/BRIEF.md
# IO Page Table Entry Translator

This block turns one device (DMA) virtual address into a physical address by reading a single page-table entry from memory. When a request is accepted it captures the virtual address, a read/write flag, the table base value and the size code of the translation window. From these it forms the byte address of the entry. It then issues one 32-bit read on a simple memory port with a valid/ready request and a one-cycle response strobe.

When the entry returns, the block checks the entry's present and write-permit bits. It then answers with either a 36-bit physical address or a fault. A fault carries the page-aligned virtual address and a read indication, which a neighbouring register block captures. Nothing is cached between requests, the walk has one level, and only one request is in flight at a time.

Top module: `iopte_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `busy`, `mem_req_valid` and `rsp_valid` are 0.
- R2: The entry address is `(req_base << 4) + ((vaddr & (2^(24+req_range) - 1)) >> 10 with bits [1:0] cleared)`, truncated to 36 bits. `req_range` codes 0 to 7 select window sizes of 16 MB, 32 MB, 64 MB, 128 MB, 256 MB, 512 MB, 1 GB and 2 GB.
- R3: When no fault occurs, `rsp_paddr` is the entry's bits [31:8] placed at [35:12], with vaddr[11:0] below them.
- R4: An entry whose bit 1 (present) is 0 makes the response a fault, whether the access is a read or a write.
- R5: A write to a present entry whose bit 2 (write permit) is 0 faults. A read of such an entry does not fault.
- R6: `rsp_rd` is 1 for a read request and 0 for a write request. `rsp_fault_addr` is the request vaddr with bits [11:0] cleared.
- R7: `busy` is 1 from the cycle after request acceptance until the cycle after the response handshake. While busy, `req_ready` is 0 and further requests, and changes on the request inputs, are ignored.
- R8: `mem_req_valid` with a stable `mem_req_addr` holds until `mem_req_ready`. `rsp_valid` with stable response fields holds until `rsp_ready`.
- R9: `rsp_cacheable` equals bit 7 of the fetched entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_range | input | 3 | Window size code |
| req_base | input | 32 | Page table base value |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the entry read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data strobe |
| mem_rsp_data | input | 32 | Fetched entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 36 | Physical address |
| rsp_fault | output | 1 | Translation faulted |
| rsp_rd | output | 1 | Faulting or translated access was a read |
| rsp_fault_addr | output | 32 | Page-aligned virtual address |
| rsp_cacheable | output | 1 | Entry cacheable bit |

## Verification
The sweep runs every window size code against three kinds of address:
- one near the top of the address space;
- one sitting exactly on the window start;
- one scattered pattern whose upper bits lie outside the window.

Together these show whether the mask grows one bit per code and whether bits above the window leak into the entry index. Each address is paired with all four present/write-permit combinations under both reads and writes. This separates a missing-entry fault from a permission fault and shows that reads ignore the permit bit. Grant delay, response delay and result back-pressure are varied, and a second request is pushed in while the block is busy, to show that captured fields and held outputs are independent of port timing.

// File: rtl/iox_pkg.sv
package iox_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } iox_state_e;

   // entry flag positions used by the checker
   localparam int unsigned FLG_PRESENT = 1;
   localparam int unsigned FLG_WPERMIT = 2;
   localparam int unsigned FLG_CACHE   = 7;
   localparam int unsigned FLG_LOW_W   = 8;
endpackage

// File: rtl/iox_addr_gen.sv
module iox_addr_gen #(
   parameter int unsigned VA_W         = 32,
   parameter int unsigned BASE_W       = 32,
   parameter int unsigned RANGE_W      = 3,
   parameter int unsigned MIN_WIN_LOG2 = 24,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned EA_W         = BASE_W + 4
) (
   input  logic [VA_W-1:0]    vaddr,
   input  logic [BASE_W-1:0]  base,
   input  logic [RANGE_W-1:0] rng,
   output logic [EA_W-1:0]    entry_addr
);
   localparam int unsigned IDX_SHIFT = PAGE_SHIFT - 2;

   logic [VA_W-1:0] keep;
   logic [VA_W-1:0] win_off;
   logic [EA_W-1:0] idx;

   // per-bit window mask: bit kept when below 2^(MIN_WIN_LOG2 + rng)
   for (genvar i = 0; i < VA_W; i++) begin : g_mask
      if (i < MIN_WIN_LOG2) begin : g_fixed
         assign keep[i] = 1'b1;
      end else begin : g_var
         assign keep[i] = (32'(rng) + 32'(MIN_WIN_LOG2)) > 32'(i);
      end
   end

   assign win_off    = vaddr & keep;
   assign idx        = (EA_W'(win_off) >> IDX_SHIFT) & ~EA_W'(3);
   assign entry_addr = (EA_W'(base) << 4) + idx;
endmodule

// File: rtl/iox_pte_check.sv
module iox_pte_check
   import iox_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PTE_W      = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PA_W       = PTE_W - FLG_LOW_W + PAGE_SHIFT
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [VA_W-1:0]  vaddr,
   input  logic             is_write,
   output logic [PA_W-1:0]  paddr,
   output logic             fault,
   output logic             cacheable,
   output logic [VA_W-1:0]  fault_addr
);
   logic present, wpermit;
   logic unused_flags;

   assign present   = pte[FLG_PRESENT];
   assign wpermit   = pte[FLG_WPERMIT];
   assign cacheable = pte[FLG_CACHE];

   always_comb begin
      fault = 1'b0;
      if (!present)
         fault = 1'b1;
      else if (is_write && !wpermit)
         fault = 1'b1;
   end

   assign paddr      = {pte[PTE_W-1:FLG_LOW_W], vaddr[PAGE_SHIFT-1:0]};
   assign fault_addr = {vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

   assign unused_flags = ^{pte[6:3], pte[0]};
endmodule

// File: rtl/iox_seq.sv
module iox_seq
   import iox_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   input  logic rsp_ready,
   output logic req_ready,
   output logic mem_req_valid,
   output logic rsp_valid,
   output logic busy,
   output logic accept,
   output logic capture
);
   iox_state_e state_q, state_d;

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_FETCH);
   assign rsp_valid     = (state_q == ST_RESP);
   assign busy          = (state_q != ST_IDLE);
   assign accept        = req_ready && req_valid;
   assign capture       = (state_q == ST_WAIT) && mem_rsp_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid)     state_d = ST_FETCH;
         ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
         ST_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
         ST_RESP:  if (rsp_ready)     state_d = ST_IDLE;
         default:                     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid);
   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid);
   // R7
   single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, mem_req_valid, rsp_valid}));
   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ready |=> !busy);
endmodule

// File: rtl/iopte_xlate.sv
module iopte_xlate
   import iox_pkg::*;
#(
   parameter int unsigned VA_W         = 32,
   parameter int unsigned BASE_W       = 32,
   parameter int unsigned RANGE_W      = 3,
   parameter int unsigned MIN_WIN_LOG2 = 24,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned PTE_W        = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [VA_W-1:0]     req_vaddr,
   input  logic                req_write,
   input  logic [RANGE_W-1:0]  req_range,
   input  logic [BASE_W-1:0]   req_base,
   output logic                busy,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [BASE_W+3:0]   mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [PTE_W-1:0]    mem_rsp_data,
   output logic                rsp_valid,
   input  logic                rsp_ready,
   output logic [PTE_W-FLG_LOW_W+PAGE_SHIFT-1:0] rsp_paddr,
   output logic                rsp_fault,
   output logic                rsp_rd,
   output logic [VA_W-1:0]     rsp_fault_addr,
   output logic                rsp_cacheable
);
   localparam int unsigned EA_W = BASE_W + 4;
   localparam int unsigned PA_W = PTE_W - FLG_LOW_W + PAGE_SHIFT;
   localparam int unsigned MAX_WIN_LOG2 = MIN_WIN_LOG2 + (1 << RANGE_W) - 1;

   // elaboration-time parameter checks
   if (PAGE_SHIFT < 3 || PAGE_SHIFT >= VA_W) begin : g_bad_page
      $error("iopte_xlate: PAGE_SHIFT out of range");
   end
   if (MAX_WIN_LOG2 > VA_W) begin : g_bad_window
      $error("iopte_xlate: largest window exceeds VA_W");
   end
   if (EA_W < VA_W) begin : g_bad_ea
      $error("iopte_xlate: entry address narrower than VA_W");
   end
   if (PTE_W <= FLG_LOW_W) begin : g_bad_pte
      $error("iopte_xlate: PTE_W too small");
   end

   logic                accept, capture;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic [RANGE_W-1:0]  rng_q;
   logic [BASE_W-1:0]   base_q;
   logic [PTE_W-1:0]    pte_q;
   logic [PA_W-1:0]     paddr_w;
   logic                fault_w, cache_w;
   logic [VA_W-1:0]     faddr_w;

   iox_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_ready     (rsp_ready),
      .req_ready     (req_ready),
      .mem_req_valid (mem_req_valid),
      .rsp_valid     (rsp_valid),
      .busy          (busy),
      .accept        (accept),
      .capture       (capture)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q   <= '0;
         wr_q   <= 1'b0;
         rng_q  <= '0;
         base_q <= '0;
         pte_q  <= '0;
      end else begin
         if (accept) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            rng_q  <= req_range;
            base_q <= req_base;
         end
         if (capture)
            pte_q <= mem_rsp_data;
      end
   end

   iox_addr_gen #(
      .VA_W         (VA_W),
      .BASE_W       (BASE_W),
      .RANGE_W      (RANGE_W),
      .MIN_WIN_LOG2 (MIN_WIN_LOG2),
      .PAGE_SHIFT   (PAGE_SHIFT),
      .EA_W         (EA_W)
   ) u_addr (
      .vaddr      (va_q),
      .base       (base_q),
      .rng        (rng_q),
      .entry_addr (mem_req_addr)
   );

   iox_pte_check #(
      .VA_W       (VA_W),
      .PTE_W      (PTE_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .PA_W       (PA_W)
   ) u_chk (
      .pte        (pte_q),
      .vaddr      (va_q),
      .is_write   (wr_q),
      .paddr      (paddr_w),
      .fault      (fault_w),
      .cacheable  (cache_w),
      .fault_addr (faddr_w)
   );

   assign rsp_paddr      = paddr_w;
   assign rsp_fault      = fault_w;
   assign rsp_rd         = !wr_q;
   assign rsp_fault_addr = faddr_w;
   assign rsp_cacheable  = cache_w;

   // R8
   mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
   // R8
   rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> $stable({rsp_paddr, rsp_fault, rsp_rd, rsp_fault_addr}));
   // R2
   entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy && !req_ready);
endmodule

// File: tb/iopte_xlate_tb_top.sv
module iopte_xlate_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_vaddr = '0, req_base = '0;
   logic [2:0]  req_range = '0;
   logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, rsp_ready = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        req_ready, busy, mem_req_valid, rsp_valid;
   logic        rsp_fault, rsp_rd, rsp_cacheable;
   logic [35:0] mem_req_addr, rsp_paddr;
   logic [31:0] rsp_fault_addr;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iopte_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_range(req_range), .req_base(req_base),
      .busy(busy),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_rd(rsp_rd), .rsp_fault_addr(rsp_fault_addr),
      .rsp_cacheable(rsp_cacheable)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xact(input logic [31:0] va, input logic wr, input logic [2:0] rg,
                       input logic [31:0] bs, input logic [31:0] pte,
                       input int gd, input int ld, input int bp);
      logic [63:0] off, ea, pa;
      logic        flt;
      off = 64'(va) & ((64'd1 << (24 + rg)) - 64'd1);
      ea  = ((64'(bs) << 4) + ((off >> 10) & ~64'd3)) & 64'hF_FFFF_FFFF;
      pa  = (64'(pte) >> 8) * 64'd4096 + (64'(va) & 64'hFFF);
      flt = !pte[1] || (wr && !pte[2]);

      @(negedge clk);
      check("R7 ready when idle", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_range = rg; req_base = bs;
      @(negedge clk);
      // R7: a second request with different fields must be ignored
      req_vaddr = ~va; req_write = ~wr; req_range = ~rg; req_base = ~bs;
      check("R7 busy after accept", 64'(busy), 64'd1);
      check("R2 entry addr", 64'(mem_req_addr), ea);
      for (int i = 0; i < gd; i++) begin
         @(negedge clk);
         check("R8 mem req held", 64'({mem_req_valid, mem_req_addr}), {27'd0, 1'b1, ea[35:0]});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check("R8 mem req dropped", 64'(mem_req_valid), 64'd0);
      for (int i = 0; i < ld; i++) begin
         @(negedge clk);
         check("R7 no result while waiting", 64'({rsp_valid, req_ready}), 64'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = ~pte;
      check("R8 rsp valid", 64'(rsp_valid), 64'd1);
      if (!pte[1]) check("R4 absent entry fault", 64'(rsp_fault), 64'd1);
      else         check("R5 permit fault", 64'(rsp_fault), 64'(flt));
      check("R6 read flag", 64'(rsp_rd), 64'(!wr));
      check("R6 fault addr", 64'(rsp_fault_addr), 64'(va) & 64'hFFFF_F000);
      check("R9 cacheable", 64'(rsp_cacheable), 64'(pte[7]));
      if (!flt) check("R3 paddr", 64'(rsp_paddr), pa);
      for (int i = 0; i < bp; i++) begin
         @(negedge clk);
         check("R8 rsp held", 64'({rsp_valid, rsp_fault, rsp_rd}), 64'({1'b1, flt, !wr}));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b0;
      check("R7 idle after handshake", 64'({busy, rsp_valid, req_ready}), 64'b001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] va, bs, pte;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 req_ready", 64'(req_ready), 64'd1);
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      for (int rg = 0; rg < 8; rg++) begin
         for (int k = 0; k < 3; k++) begin
            case (k)
               0:       va = 32'hFFFF_F123;
               1:       va = (32'hFFFF_FFFF << (24 + rg)) | 32'h0000_0ABC;
               default: va = 32'h8765_4321 ^ (32'(rg) << 20);
            endcase
            bs = 32'h0123_4560 + 32'(rg) * 32'h0001_0400;
            for (int f = 0; f < 8; f++) begin
               pte = {24'h5A_C310 + 24'(rg * 97 + k * 13 + f), 1'(f ^ rg),
                      4'b1010, 1'(f >> 1), 1'(f), 1'b1};
               xact(va, 1'(f >> 2), 3'(rg), bs, pte, f % 3, (k + f) % 3, rg % 2);
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule